// File: doc/BRIEF.md
# Fetch-and-Add Request Combiner

This unit sits between two requesters and a single memory port that performs atomic fetch-and-add. Each request carries a tag, an address and an addend. Suppose both requesters present a request to the same address in the same cycle, and the wait buffer has room. The unit then sends one memory request in their place. That request carries requester 0's tag and the wrapped sum of the two addends. It records requester 1's tag and requester 0's addend in a small wait buffer, keyed by the forwarded tag.

When the memory reply returns the old value `v` for a combined tag, the unit splits it into two replies on one output channel. Requester 0 gets `v` unchanged. In the next cycle, requester 1 gets `v` plus requester 0's addend. Both results are the same as if requester 0's add had run first and requester 1's add directly after it. Requests to different addresses are not combined: they go to memory one at a time, input 0 first. A reply whose tag has no wait-buffer entry is passed straight through.

Top module: `fadd_combiner`

## Requirements
- R1: When both requests are valid with equal addresses and the wait buffer is not full, `mem_valid` is high, `mem_tag` equals `req0_tag`, `mem_addr` equals the shared address, and `mem_add` equals `(req0_add + req1_add) mod 2^DATA_W`. Both readies equal `mem_ready`.
- R2: A reply accepted at a clock edge (`rep_valid` and `rep_ready` high) appears at the next edge on `rsp_valid`/`rsp_tag`/`rsp_data`, with its tag and data unchanged.
- R3: If the accepted reply's tag matches a wait-buffer entry, the cycle after the first reply carries the stored second tag. Its data is `(reply data + stored first addend) mod 2^DATA_W`, and that entry is released.
- R4: When both requests are valid with different addresses, request 0 is forwarded alone and `req1_ready` is low. With only request 1 valid, request 1 is forwarded alone.
- R5: The wait buffer holds up to DEPTH (default 4) entries. Entries are found by tag regardless of the order of the replies.
- R6: While the wait buffer is full, an equal-address pair is held: `mem_valid`, `req0_ready` and `req1_ready` are low. A lone request is still forwarded.
- R7: A reply whose tag has no entry produces exactly one output reply. `rsp_valid` is low in the following cycle when no new reply arrives.
- R8: `rep_ready` is low exactly in the cycle in which a split second reply is pending, and `rsp_valid` is high in the cycle that follows.
- R9: With `mem_ready` low, neither request is accepted.
- R10: After reset `rsp_valid` is low, `rep_ready` is high and, with no request valid, `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req0_valid | input | 1 | Request 0 present |
| req0_tag | input | TAG_W | Request 0 tag |
| req0_addr | input | ADDR_W | Request 0 address |
| req0_add | input | DATA_W | Request 0 addend |
| req0_ready | output | 1 | Request 0 accepted |
| req1_valid | input | 1 | Request 1 present |
| req1_tag | input | TAG_W | Request 1 tag |
| req1_addr | input | ADDR_W | Request 1 address |
| req1_add | input | DATA_W | Request 1 addend |
| req1_ready | output | 1 | Request 1 accepted |
| mem_valid | output | 1 | Memory request present |
| mem_tag | output | TAG_W | Forwarded tag |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_add | output | DATA_W | Forwarded addend (sum when combined) |
| mem_ready | input | 1 | Memory accepts request |
| rep_valid | input | 1 | Memory reply present |
| rep_tag | input | TAG_W | Memory reply tag |
| rep_data | input | DATA_W | Old value returned by memory |
| rep_ready | output | 1 | Unit accepts memory reply |
| rsp_valid | output | 1 | Reply to a requester |
| rsp_tag | output | TAG_W | Tag of the reply to a requester |
| rsp_data | output | DATA_W | Old value seen by that requester |

## Verification
The bench runs the combine-then-reply sequence over every pair of 4-bit addends. Each pair gets a different returned value. The sweep separates a wrapped sum from an unwrapped one, and the second reply's `v + f` from `v + g` or `v + f + g`. The wait buffer is filled to its depth and then drained out of order, which shows that entries are found by tag and not by position. It also shows that a pair is held while the buffer is full and a lone request still passes. Further patterns cover a different-address pair, a reply with no entry, and a stalled memory port. These show the ordering, the pass-through and the back-pressure.

// File: rtl/fac_pkg.sv
package fac_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_PAIR = 2'd1,
    RT_REQ0 = 2'd2,
    RT_REQ1 = 2'd3
  } route_e;
endpackage

// File: rtl/fac_match.sv
module fac_match
  import fac_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 6
) (
  input  logic          v0,
  input  logic [TW-1:0] t0,
  input  logic [AW-1:0] a0,
  input  logic [DW-1:0] d0,
  input  logic          v1,
  input  logic [TW-1:0] t1,
  input  logic [AW-1:0] a1,
  input  logic [DW-1:0] d1,
  input  logic          buf_full,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [TW-1:0] mem_tag,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_add,
  output logic          rdy0,
  output logic          rdy1,
  output logic          alloc_en,
  output route_e        route
);
  function automatic logic [DW-1:0] sum_wrap(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  logic same_addr;
  assign same_addr = v0 && v1 && (a0 == a1);

  always_comb begin
    if (same_addr && !buf_full) route = RT_PAIR;
    else if (same_addr)         route = RT_NONE;
    else if (v0)                route = RT_REQ0;
    else if (v1)                route = RT_REQ1;
    else                        route = RT_NONE;
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_tag   = t0;
    mem_addr  = a0;
    mem_add   = d0;
    rdy0      = 1'b0;
    rdy1      = 1'b0;
    alloc_en  = 1'b0;
    unique case (route)
      RT_PAIR: begin
        mem_valid = 1'b1;
        mem_add   = sum_wrap(d0, d1);
        rdy0      = mem_ready;
        rdy1      = mem_ready;
        alloc_en  = mem_ready;
      end
      RT_REQ0: begin
        mem_valid = 1'b1;
        rdy0      = mem_ready;
      end
      RT_REQ1: begin
        mem_valid = 1'b1;
        mem_tag   = t1;
        mem_addr  = a1;
        mem_add   = d1;
        rdy1      = mem_ready;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fac_wait_buf.sv
module fac_wait_buf #(
  parameter int TW    = 6,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [TW-1:0] alloc_key,
  input  logic [TW-1:0] alloc_tag2,
  input  logic [DW-1:0] alloc_add1,
  input  logic [TW-1:0] look_key,
  input  logic          free_en,
  output logic          full,
  output logic          hit,
  output logic [TW-1:0] hit_tag2,
  output logic [DW-1:0] hit_add1
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slot_v;
  logic [TW-1:0]    slot_key  [DEPTH];
  logic [TW-1:0]    slot_tag2 [DEPTH];
  logic [DW-1:0]    slot_add1 [DEPTH];
  logic [IW-1:0]    free_idx, hit_idx;
  logic             have_free;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_v[i]) begin
        free_idx  = IW'(i);
        have_free = 1'b1;
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    hit     = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (slot_v[i] && slot_key[i] == look_key) begin
        hit_idx = IW'(i);
        hit     = 1'b1;
      end
    end
  end

  assign full     = &slot_v;
  assign hit_tag2 = slot_tag2[hit_idx];
  assign hit_add1 = slot_add1[hit_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[g]    <= 1'b0;
        slot_key[g]  <= '0;
        slot_tag2[g] <= '0;
        slot_add1[g] <= '0;
      end else if (alloc_en && have_free && free_idx == IW'(g)) begin
        slot_v[g]    <= 1'b1;
        slot_key[g]  <= alloc_key;
        slot_tag2[g] <= alloc_tag2;
        slot_add1[g] <= alloc_add1;
      end else if (free_en && hit && hit_idx == IW'(g)) begin
        slot_v[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fac_reply_split.sv
module fac_reply_split #(
  parameter int TW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rep_valid,
  input  logic [TW-1:0] rep_tag,
  input  logic [DW-1:0] rep_data,
  input  logic          hit,
  input  logic [TW-1:0] hit_tag2,
  input  logic [DW-1:0] hit_add1,
  output logic          rep_ready,
  output logic          free_en,
  output logic          pending,
  output logic          rsp_valid,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data
);
  function automatic logic [DW-1:0] serial_after(input logic [DW-1:0] old_v, input logic [DW-1:0] first_add);
    return old_v + first_add;
  endfunction

  logic [TW-1:0] sec_tag;
  logic [DW-1:0] sec_data;

  assign rep_ready = !pending;
  assign free_en   = rep_valid && !pending && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
      sec_tag   <= '0;
      sec_data  <= '0;
    end else if (pending) begin
      rsp_valid <= 1'b1;
      rsp_tag   <= sec_tag;
      rsp_data  <= sec_data;
      pending   <= 1'b0;
    end else if (rep_valid) begin
      rsp_valid <= 1'b1;
      rsp_tag   <= rep_tag;
      rsp_data  <= rep_data;
      if (hit) begin
        pending  <= 1'b1;
        sec_tag  <= hit_tag2;
        sec_data <= serial_after(rep_data, hit_add1);
      end
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fadd_combiner.sv
module fadd_combiner
  import fac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0_valid,
  input  logic [TAG_W-1:0]  req0_tag,
  input  logic [ADDR_W-1:0] req0_addr,
  input  logic [DATA_W-1:0] req0_add,
  output logic              req0_ready,
  input  logic              req1_valid,
  input  logic [TAG_W-1:0]  req1_tag,
  input  logic [ADDR_W-1:0] req1_addr,
  input  logic [DATA_W-1:0] req1_add,
  output logic              req1_ready,
  output logic              mem_valid,
  output logic [TAG_W-1:0]  mem_tag,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_add,
  input  logic              mem_ready,
  input  logic              rep_valid,
  input  logic [TAG_W-1:0]  rep_tag,
  input  logic [DATA_W-1:0] rep_data,
  output logic              rep_ready,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);
  logic              buf_full, alloc_en, free_en, hit, split_pend;
  logic [TAG_W-1:0]  hit_tag2;
  logic [DATA_W-1:0] hit_add1;
  route_e            route;

  fac_match #(.AW(ADDR_W), .DW(DATA_W), .TW(TAG_W)) u_match (
    .v0(req0_valid), .t0(req0_tag), .a0(req0_addr), .d0(req0_add),
    .v1(req1_valid), .t1(req1_tag), .a1(req1_addr), .d1(req1_add),
    .buf_full(buf_full), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_tag(mem_tag), .mem_addr(mem_addr), .mem_add(mem_add),
    .rdy0(req0_ready), .rdy1(req1_ready), .alloc_en(alloc_en), .route(route)
  );

  fac_wait_buf #(.TW(TAG_W), .DW(DATA_W), .DEPTH(DEPTH)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_key(req0_tag), .alloc_tag2(req1_tag), .alloc_add1(req0_add),
    .look_key(rep_tag), .free_en(free_en),
    .full(buf_full), .hit(hit), .hit_tag2(hit_tag2), .hit_add1(hit_add1)
  );

  fac_reply_split #(.TW(TAG_W), .DW(DATA_W)) u_split (
    .clk(clk), .rst_n(rst_n),
    .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_data(rep_data),
    .hit(hit), .hit_tag2(hit_tag2), .hit_add1(hit_add1),
    .rep_ready(rep_ready), .free_en(free_en), .pending(split_pend),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/fadd_combiner_chk.sv
module fadd_combiner_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req0_valid,
  input logic [TW-1:0] req0_tag,
  input logic [AW-1:0] req0_addr,
  input logic          req0_ready,
  input logic          req1_valid,
  input logic [AW-1:0] req1_addr,
  input logic          req1_ready,
  input logic          mem_valid,
  input logic [TW-1:0] mem_tag,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          rep_valid,
  input logic [TW-1:0] rep_tag,
  input logic [DW-1:0] rep_data,
  input logic          rep_ready,
  input logic          rsp_valid,
  input logic [TW-1:0] rsp_tag,
  input logic [DW-1:0] rsp_data,
  input logic          buf_full,
  input logic          split_pend
);
  p_pair_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_ready && req1_ready) |-> (mem_valid && mem_tag == req0_tag && mem_addr == req1_addr));

  p_reply_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_ready) |=> (rsp_valid && rsp_tag == $past(rep_tag) && rsp_data == $past(rep_data)));

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_valid && req1_valid && req0_addr != req1_addr) |-> !req1_ready);

  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && req0_valid && req1_valid && req0_addr == req1_addr) |-> (!mem_valid && !req0_ready && !req1_ready));

  p_second_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_ready |=> rsp_valid);

  p_stall_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rep_ready != split_pend);

  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (!req0_ready && !req1_ready));
endmodule

bind fadd_combiner fadd_combiner_chk #(.AW(ADDR_W), .DW(DATA_W), .TW(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req0_valid(req0_valid), .req0_tag(req0_tag), .req0_addr(req0_addr), .req0_ready(req0_ready),
  .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_ready(req1_ready),
  .mem_valid(mem_valid), .mem_tag(mem_tag), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_data(rep_data), .rep_ready(rep_ready),
  .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
  .buf_full(buf_full), .split_pend(split_pend)
);

// File: tb/fadd_combiner_bench.sv
module fadd_combiner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 4, TW = 4, DEPTH = 4;
  localparam int MODV = 1 << DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req0_valid = 0, req1_valid = 0, mem_ready = 1, rep_valid = 0;
  logic [TW-1:0] req0_tag = 0, req1_tag = 0, rep_tag = 0;
  logic [AW-1:0] req0_addr = 0, req1_addr = 0;
  logic [DW-1:0] req0_add = 0, req1_add = 0, rep_data = 0;
  logic req0_ready, req1_ready, mem_valid, rep_ready, rsp_valid;
  logic [TW-1:0] mem_tag, rsp_tag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_add, rsp_data;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fadd_combiner #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .DEPTH(DEPTH)) u_fadd_combiner (
    .clk(clk), .rst_n(rst_n),
    .req0_valid(req0_valid), .req0_tag(req0_tag), .req0_addr(req0_addr), .req0_add(req0_add), .req0_ready(req0_ready),
    .req1_valid(req1_valid), .req1_tag(req1_tag), .req1_addr(req1_addr), .req1_add(req1_add), .req1_ready(req1_ready),
    .mem_valid(mem_valid), .mem_tag(mem_tag), .mem_addr(mem_addr), .mem_add(mem_add), .mem_ready(mem_ready),
    .rep_valid(rep_valid), .rep_tag(rep_tag), .rep_data(rep_data), .rep_ready(rep_ready),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offer a same-address pair for one edge and check the forwarded request (R1).
  task automatic send_pair(input int t0, input int t1, input int ad, input int f, input int g);
    @(negedge clk);
    req0_valid = 1; req0_tag = TW'(t0); req0_addr = AW'(ad); req0_add = DW'(f);
    req1_valid = 1; req1_tag = TW'(t1); req1_addr = AW'(ad); req1_add = DW'(g);
    #1;
    chk(mem_valid && mem_tag == TW'(t0) && mem_addr == AW'(ad), "R1 tag/addr", int'(mem_tag), t0);
    chk(int'(mem_add) == (f + g) % MODV, "R1 sum", int'(mem_add), (f + g) % MODV);
    chk(req0_ready && req1_ready, "R1 readies", int'({req0_ready, req1_ready}), 3);
    @(posedge clk);
    @(negedge clk);
    req0_valid = 0; req1_valid = 0;
  endtask

  // Return a reply; if split, expect second reply with t1 and v+f.
  task automatic reply(input int t, input int v, input bit split, input int t1, input int f);
    @(negedge clk);
    rep_valid = 1; rep_tag = TW'(t); rep_data = DW'(v);
    #1;
    chk(rep_ready, "R2 rep_ready", int'(rep_ready), 1);
    @(posedge clk);
    @(negedge clk);
    rep_valid = 0;
    chk(rsp_valid && rsp_tag == TW'(t) && int'(rsp_data) == v, "R2 first reply", int'(rsp_data), v);
    if (split) begin
      chk(!rep_ready, "R8 rep_ready low while pending", int'(rep_ready), 0);
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid && rsp_tag == TW'(t1), "R3 second tag", int'(rsp_tag), t1);
      chk(int'(rsp_data) == (v + f) % MODV, "R3 second data", int'(rsp_data), (v + f) % MODV);
    end else begin
      chk(rep_ready, "R7 no stall", int'(rep_ready), 1);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R7 single reply only", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!rsp_valid, "R10 rsp_valid", int'(rsp_valid), 0);
    chk(rep_ready, "R10 rep_ready", int'(rep_ready), 1);
    chk(!mem_valid, "R10 mem_valid", int'(mem_valid), 0);

    // Exhaustive addend sweep: R1, R2, R3.
    for (int f = 0; f < MODV; f++) begin
      for (int g = 0; g < MODV; g++) begin
        int v;
        v = (f * 7 + g * 3 + 5) % MODV;
        send_pair(f % 8, 8 + (g % 8), (f + g) % 16, f, g);
        reply(f % 8, v, 1'b1, 8 + (g % 8), f);
      end
    end

    // R5/R6: fill buffer with tags 0..3, then pair held, lone request passes.
    for (int k = 0; k < DEPTH; k++) send_pair(k, 8 + k, k, k + 1, 2);
    @(negedge clk);
    req0_valid = 1; req0_tag = 4; req0_addr = 9; req0_add = 1;
    req1_valid = 1; req1_tag = 12; req1_addr = 9; req1_add = 1;
    #1;
    chk(!mem_valid && !req0_ready && !req1_ready, "R6 pair held when full", int'(mem_valid), 0);
    @(negedge clk);
    req1_valid = 0;
    #1;
    chk(mem_valid && req0_ready && mem_tag == 4'd4, "R6 lone request passes", int'(mem_tag), 4);
    @(posedge clk);
    @(negedge clk);
    req0_valid = 0;
    // Drain out of order (R5).
    reply(2, 5, 1'b1, 10, 3);
    reply(0, 15, 1'b1, 8, 1);
    reply(3, 9, 1'b1, 11, 4);
    reply(1, 6, 1'b1, 9, 2);
    // Tag 4 was forwarded alone: pass-through (R7).
    reply(4, 13, 1'b0, 0, 0);

    // R4: different addresses.
    @(negedge clk);
    req0_valid = 1; req0_tag = 1; req0_addr = 2; req0_add = 3;
    req1_valid = 1; req1_tag = 9; req1_addr = 5; req1_add = 6;
    #1;
    chk(mem_valid && mem_tag == 4'd1 && mem_add == 4'd3, "R4 input 0 first", int'(mem_tag), 1);
    chk(req0_ready && !req1_ready, "R4 input 1 waits", int'(req1_ready), 0);
    @(posedge clk);
    @(negedge clk);
    req0_valid = 0;
    #1;
    chk(mem_valid && mem_tag == 4'd9 && mem_addr == 4'd5 && mem_add == 4'd6, "R4 input 1 next", int'(mem_tag), 9);
    @(posedge clk);
    @(negedge clk);
    req1_valid = 0;
    reply(1, 7, 1'b0, 0, 0);

    // R9: memory stalled.
    @(negedge clk);
    mem_ready = 0;
    req0_valid = 1; req0_tag = 2; req0_addr = 3; req0_add = 1;
    req1_valid = 1; req1_tag = 10; req1_addr = 3; req1_add = 2;
    #1;
    chk(!req0_ready && !req1_ready, "R9 nothing accepted", int'({req0_ready, req1_ready}), 0);
    @(negedge clk);
    mem_ready = 1;
    req0_valid = 0; req1_valid = 0;
    // Pair never accepted, so tag 2 has no entry: passes through (R7).
    reply(2, 11, 1'b0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule